// File: doc/BRIEF.md
# Turn-Notch Transverse Damper Filter

This block is the digital core of a transverse feedback loop. It sits between a stream of beam-position samples and the sample stream that drives a kicker amplifier. Samples arrive at four times the bunch frequency. Each incoming sample is added to the three before it, so that a boxcar removes the bunch-frequency harmonics. The boxcar sum is then compared against the sum taken exactly one revolution earlier, which removes every revolution harmonic: a closed orbit produces no kick, and only the turn-to-turn motion passes through. The difference is multiplied by a signed fixed-point gain, clipped to the output converter range, and delayed by a programmable number of samples so that the kick lands on the same bunch.

Every step advances once per accepted sample. The length of one turn in samples, the gain and the delay are held in a small register port with separate write and read paths. The length of one turn sets the depth of a circular buffer. A watchdog counts edges of the RF reference in fixed windows of the local clock. When the count is out of tolerance, it latches a fault that mutes the output until software clears it. After a clear, or after a new turn length is written, the output stays at zero until a complete turn of fresh data sits in the buffer.

Top module: `damper_notch_filter`

## Requirements
- R1: `out_valid` is high in the cycle after each cycle in which `in_valid` is high, and low otherwise. The filter state advances only on cycles with `in_valid` high.
- R2: The boxcar value for sample k is the sum of samples k, k-1, k-2 and k-3. It is not divided, and samples before reset count as zero. As a result, any pattern that repeats every four samples and sums to zero over one period produces a zero output.
- R3: The notch value for sample k is the boxcar value of sample k minus the boxcar value of sample k-L, where L is the turn length. An input that repeats every L samples therefore gives a zero output once the buffer holds a full turn.
- R4: The gain stage forms notch value × gain. The gain is two's complement with FRAC=8 fractional bits, and the product is shifted right arithmetically by FRAC, which rounds toward minus infinity. After the edge that accepts sample k, `out_sample` shows the result for sample k-1-D, where D is the delay register.
- R5: The scaled result is saturated to the signed DAC_W range (−8192..8191 by default) and never wraps.
- R6: Address 2 holds the delay D. A write of a value of MAX_DLY (16) or more is ignored.
- R7: Address 0 holds the turn length L. A write of 0 or of a value above DEPTH (1024) is ignored. A write in range restarts the buffer position and the refill count.
- R8: Sample k contributes a non-zero output only if at least L samples were accepted since the last restart. Until then, its output slot is zero.
- R9: In every window of WIN=64 clocks, rising edges of `rf_ref` are counted. A count below 12 or above 20 sets `fault`, which is also status bit 0 at address 3. While `fault` is high, `out_sample` is zero and samples do not count toward refill.
- R10: `fault` is sticky. Only a write to address 3 with bit 0 set clears it. After the clear, the refill rule of R8 starts again from zero.
- R11: After reset, L reads 1024, the gain reads 256 (a gain of 1.0), D reads 0, `fault` is low, and the output is zero and not valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A new position sample is present |
| in_sample | input | ADC_W | Signed position sample |
| rf_ref | input | 1 | RF reference, sampled asynchronously |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 turn length, 1 gain, 2 delay, 3 status |
| reg_wdata | input | GAIN_W | Register write data |
| reg_rdata | output | GAIN_W | Read data for `reg_addr`, combinational |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | DAC_W | Signed kick sample |
| fault | output | 1 | Sticky RF-reference fault |

## Verification
The bench targets the boundaries where this filter is easy to get wrong by one sample. A notch that reads the buffer one slot off, or a delay tap that is off by one, would show a residual on a turn-periodic input, or a sample that appears one slot early or late. A refill counter that releases too early would pass stale buffer contents on the first turn after a restart or a fault clear. The saturation tests drive full-scale steps of both signs, so that a design that wraps would flip the sign of the kick. The watchdog tests stop the reference and then overdrive it, and they check that the fault persists after the reference recovers. A bit that cleared itself would let the output resume without a software clear.

// File: rtl/damper_notch_filter.sv
module damper_notch_filter #(
  parameter int ADC_W    = 12,
  parameter int DAC_W    = 14,
  parameter int GAIN_W   = 16,
  parameter int FRAC     = 8,
  parameter int DEPTH    = 1024,
  parameter int MAX_DLY  = 16,
  parameter int WIN      = 64,
  parameter int EDGE_MIN = 12,
  parameter int EDGE_MAX = 20
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [ADC_W-1:0]  in_sample,
  input  logic                     rf_ref,
  input  logic                     reg_we,
  input  logic [1:0]               reg_addr,
  input  logic [GAIN_W-1:0]        reg_wdata,
  output logic [GAIN_W-1:0]        reg_rdata,
  output logic                     out_valid,
  output logic signed [DAC_W-1:0]  out_sample,
  output logic                     fault
);

  localparam int SUM_W  = ADC_W + 2;
  localparam int DIF_W  = SUM_W + 1;
  localparam int PROD_W = DIF_W + GAIN_W;
  localparam int AW     = $clog2(DEPTH);
  localparam int LW     = AW + 1;
  localparam int DW     = $clog2(MAX_DLY);
  localparam int WW     = $clog2(WIN);
  localparam int EW     = $clog2(WIN + 1);
  localparam logic signed [PROD_W-1:0] SAT_HI = PROD_W'((longint'(1) <<< (DAC_W - 1)) - 1);
  localparam logic signed [PROD_W-1:0] SAT_LO = ~SAT_HI;

  // configuration registers
  logic [LW-1:0]            turn_len;
  logic signed [GAIN_W-1:0] gain;
  logic [DW-1:0]            dly;
  logic                     err;

  wire wr_turn = reg_we && reg_addr == 2'd0 && reg_wdata != '0 && reg_wdata <= GAIN_W'(DEPTH);
  wire wr_gain = reg_we && reg_addr == 2'd1;
  wire wr_dly  = reg_we && reg_addr == 2'd2 && reg_wdata < GAIN_W'(MAX_DLY);
  wire wr_clr  = reg_we && reg_addr == 2'd3 && reg_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      turn_len <= LW'(DEPTH);
      gain     <= GAIN_W'(1 << FRAC);
      dly      <= '0;
    end else begin
      if (wr_turn) turn_len <= reg_wdata[LW-1:0];
      if (wr_gain) gain     <= reg_wdata;
      if (wr_dly)  dly      <= reg_wdata[DW-1:0];
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = GAIN_W'(turn_len);
      2'd1:    reg_rdata = gain;
      2'd2:    reg_rdata = GAIN_W'(dly);
      default: reg_rdata = GAIN_W'(err);
    endcase
  end

  // four-sample boxcar
  logic signed [ADC_W-1:0] h0, h1, h2;
  logic signed [SUM_W-1:0] box;
  assign box = SUM_W'(in_sample) + SUM_W'(h0) + SUM_W'(h1) + SUM_W'(h2);

  // one-turn notch on a circular buffer
  logic signed [SUM_W-1:0] ring [DEPTH];
  logic [AW-1:0]           ptr;
  logic [LW-1:0]           fill;
  logic signed [DIF_W-1:0] diff_q;
  logic                    tag_q;
  wire  last = {1'b0, ptr} == turn_len - LW'(1);

  always_ff @(posedge clk) begin
    if (in_valid) ring[ptr] <= box;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h0 <= '0; h1 <= '0; h2 <= '0;
      ptr <= '0; diff_q <= '0; tag_q <= 1'b0;
    end else begin
      if (in_valid) begin
        h0     <= in_sample;
        h1     <= h0;
        h2     <= h1;
        diff_q <= DIF_W'(box) - DIF_W'(ring[ptr]);
        tag_q  <= !err && fill == turn_len;
        ptr    <= last ? '0 : ptr + AW'(1);
      end
      if (wr_turn) ptr <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || wr_turn || wr_clr || err) fill <= '0;
    else if (in_valid && fill != turn_len) fill <= fill + LW'(1);
  end

  // R7 buffer position stays inside the active turn
  a_r7_ptr_in_turn: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, ptr} < turn_len);
  // R7 an accepted turn-length write restarts position and refill
  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    wr_turn |=> (ptr == '0 && fill == '0));
  // R8 refill count never passes one turn
  a_r8_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= turn_len);

  // gain with saturation
  logic signed [PROD_W-1:0] scaled;
  logic signed [DAC_W-1:0]  clip;
  assign scaled = (PROD_W'(diff_q) * PROD_W'(gain)) >>> FRAC;
  assign clip   = (scaled > SAT_HI) ? SAT_HI[DAC_W-1:0] :
                  (scaled < SAT_LO) ? SAT_LO[DAC_W-1:0] : scaled[DAC_W-1:0];

  // programmable delay line
  logic signed [DAC_W-1:0] dl [MAX_DLY];
  logic [MAX_DLY-1:0]      dtag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MAX_DLY; i++) dl[i] <= '0;
      dtag      <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        dl[0] <= clip;
        for (int i = 1; i < MAX_DLY; i++) dl[i] <= dl[i-1];
        dtag  <= {dtag[MAX_DLY-2:0], tag_q};
      end
    end
  end

  assign out_sample = (dtag[dly] && !err) ? dl[dly] : '0;

  // R1 output strobe follows input strobe by one cycle
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // RF reference watchdog
  logic [2:0]    rs;
  logic [WW-1:0] win;
  logic [EW-1:0] edges;
  wire rf_edge = rs[1] & ~rs[2];
  wire win_end = win == WW'(WIN - 1);
  wire bad     = win_end && (edges < EW'(EDGE_MIN) || edges > EW'(EDGE_MAX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs <= '0; win <= '0; edges <= '0; err <= 1'b0;
    end else begin
      rs    <= {rs[1:0], rf_ref};
      win   <= win_end ? '0 : win + WW'(1);
      edges <= win_end ? EW'(rf_edge) : edges + EW'(rf_edge);
      if (bad)         err <= 1'b1;
      else if (wr_clr) err <= 1'b0;
    end
  end

  assign fault = err;

  // R9 a fault mutes the kick
  a_r9_mute_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> out_sample == '0);
  // R10 fault holds until a clear write
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !wr_clr) |=> err);

endmodule

// File: tb/sim_damper_notch_filter.sv
module sim_damper_notch_filter;
  localparam int FRAC = 8;
  localparam int OMAX = 8191;
  localparam int OMIN = -8192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [11:0] in_sample = '0;
  logic rf_ref = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic out_valid;
  logic signed [13:0] out_sample;
  logic fault;

  damper_notch_filter u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .rf_ref(rf_ref), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .out_valid(out_valid), .out_sample(out_sample), .fault(fault));

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int rf_mode = 2;
  bit ph = 1'b0;

  initial begin
    forever begin
      @(negedge clk);
      if (rf_mode == 1) rf_ref = ~rf_ref;
      else if (rf_mode == 2) begin
        ph = ~ph;
        if (ph) rf_ref = ~rf_ref;
      end
    end
  end

  // reference model state
  int L = 1024, D = 0, G = 256, cnt = 0, nsmp = 0;
  bit errm = 1'b0;
  int xs [0:2047];
  int ss [0:2047];
  longint df [0:2047];
  longint gq [0:2047];
  bit tg [0:2047];
  logic [31:0] seed = 32'h1234_5678;

  function automatic int rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed[27:16]) - 2048;
  endfunction

  function automatic longint sat(input longint v);
    if (v > OMAX) return OMAX;
    if (v < OMIN) return OMIN;
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int x, input string req);
    int k, j, e, a;
    k = nsmp;
    xs[k] = x;
    ss[k] = x + (k > 0 ? xs[k-1] : 0) + (k > 1 ? xs[k-2] : 0) + (k > 2 ? xs[k-3] : 0);
    if (errm) begin tg[k] = 1'b0; cnt = 0; end
    else begin tg[k] = (cnt >= L); cnt++; end
    df[k] = 0;
    if (tg[k]) df[k] = longint'(ss[k] - ss[k-L]);
    if (k > 0) gq[k-1] = sat((df[k-1] * G) >>> FRAC);
    @(negedge clk);
    in_valid = 1'b1;
    in_sample = 12'(x);
    @(posedge clk); #1;
    in_valid = 1'b0;
    j = k - 1 - D;
    e = 0;
    if (j >= 0 && !errm) if (tg[j]) e = int'(gq[j]);
    a = int'(out_sample);
    chk(out_valid == 1'b1, "R1", out_valid, 1);
    chk(a == e, req, a, e);
    nsmp++;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
    if (a == 2'd0 && d != 0 && d <= 1024) begin L = int'(d); cnt = 0; end
    if (a == 2'd1) G = int'($signed(d));
    if (a == 2'd2 && d < 16) D = int'(d);
    if (a == 2'd3 && d[0]) begin errm = 1'b0; cnt = 0; end
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wait_fault(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (fault) break;
    end
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk(out_valid == 1'b0, "R11", out_valid, 0);
    chk(out_sample == 0, "R11", out_sample, 0);
    chk(fault == 1'b0, "R11", fault, 0);
    rd(2'd0, v); chk(v == 16'd1024, "R11", v, 1024);
    rd(2'd1, v); chk(v == 16'd256, "R11", v, 256);
    rd(2'd2, v); chk(v == 16'd0, "R11", v, 0);
    rd(2'd3, v); chk(v == 16'd0, "R11", v, 0);
  endtask

  task automatic t_regs();
    logic [15:0] v;
    wr(2'd0, 16'd0);    rd(2'd0, v); chk(v == 16'd1024, "R7", v, 1024);
    wr(2'd0, 16'd1025); rd(2'd0, v); chk(v == 16'd1024, "R7", v, 1024);
    wr(2'd2, 16'd3);    rd(2'd2, v); chk(v == 16'd3, "R6", v, 3);
    wr(2'd2, 16'd16);   rd(2'd2, v); chk(v == 16'd3, "R6", v, 3);
    wr(2'd2, 16'd0);
    wr(2'd1, 16'hFF80); rd(2'd1, v); chk(v == 16'hFF80, "R4", v, 16'hFF80);
    wr(2'd1, 16'd256);
  endtask

  task automatic t_notch();
    wr(2'd0, 16'd8);
    for (int i = 0; i < 40; i++) push(rnd(), (i < 10) ? "R8" : "R3");
    @(negedge clk); @(posedge clk); #1;
    chk(out_valid == 1'b0, "R1", out_valid, 0);
  endtask

  task automatic t_delay();
    wr(2'd2, 16'd5);
    wr(2'd1, 16'hFE80);
    for (int i = 0; i < 30; i++) push(rnd(), "R4");
    wr(2'd2, 16'd15);
    for (int i = 0; i < 20; i++) push(rnd(), "R6");
    wr(2'd2, 16'd0);
    wr(2'd1, 16'd256);
  endtask

  task automatic t_boxcar();
    int pat [4] = '{900, 900, -900, -900};
    for (int i = 0; i < 24; i++) begin
      push(pat[i % 4], "R2");
      if (i >= 14) chk(out_sample == 0, "R2", out_sample, 0);
    end
  endtask

  task automatic t_periodic();
    int per [8];
    for (int i = 0; i < 8; i++) per[i] = rnd();
    for (int i = 0; i < 32; i++) begin
      push(per[i % 8], "R3");
      if (i >= 16) chk(out_sample == 0, "R3", out_sample, 0);
    end
  endtask

  task automatic t_sat();
    wr(2'd1, 16'd1024);
    for (int i = 0; i < 12; i++) push(0, "R5");
    for (int i = 0; i < 3; i++) push(2047, "R5");
    chk(out_sample == OMAX, "R5", out_sample, OMAX);
    for (int i = 0; i < 12; i++) push(0, "R5");
    for (int i = 0; i < 3; i++) push(-2048, "R5");
    chk(out_sample == OMIN, "R5", out_sample, OMIN);
    wr(2'd1, 16'd256);
  endtask

  task automatic t_fault(input int mode, input string req);
    logic [15:0] v;
    rf_mode = mode;
    wait_fault(300);
    chk(fault == 1'b1, req, fault, 1);
    errm = 1'b1;
    rd(2'd3, v); chk(v == 16'd1, req, v, 1);
    for (int i = 0; i < 20; i++) push(rnd(), req);
    chk(out_sample == 0, req, out_sample, 0);
    rf_mode = 2;
    repeat (150) @(negedge clk);
    chk(fault == 1'b1, "R10", fault, 1);
    wr(2'd3, 16'd1);
    chk(fault == 1'b0, "R10", fault, 0);
    for (int i = 0; i < 24; i++) push(rnd(), "R10");
    rd(2'd3, v); chk(v == 16'd0, "R10", v, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1: run hung, actual=200000 cycles expected=fewer");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_notch();
    t_delay();
    t_boxcar();
    t_periodic();
    t_sat();
    t_fault(0, "R9");
    t_fault(1, "R9");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule